// File: doc/BRIEF.md
# ADC Sample-and-Convert Timing Controller

This block times the acquisition phase and the conversion phase of a 12-bit successive-approximation converter. One of four request lines is picked: a self-clearing software start flag or one of three timer outputs. Its polarity can optionally be inverted, and it is brought into the conversion-clock domain through a two-stage synchroniser. A synchronised rising edge opens the sample window. Two sampling methods are available. In the first, the window follows the request level. In the second, a sample timer sets the window length. That length comes from one of two 4-bit codes, chosen by whether the memory slot being converted lies in the lower or the upper half of the slot range.

When the window closes, the block holds a conversion window for a fixed 13 conversion clocks. At the end of that window it captures the code that the external comparator logic presents and issues a one-cycle done strobe. The whole block runs on one system clock. The conversion clock is a clock enable: the ticks of one of four source-tick inputs are divided by a programmable factor.

Top module: `adc_timing_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, sampleWin, convBusy, busy, done, swStartBit and result are all zero until a request arrives.
- R2: The conversion clock ticks once every (clkDiv+1) ticks of the source chosen by srcSel (0..3 selects srcTick[0..3]), so every window length scales with (clkDiv+1) times the source tick period.
- R3: The conversion window (convBusy high) follows the end of the sample window directly and lasts exactly 13 conversion clocks.
- R4: With pulseMode=1 the sample window lasts 4*2^k conversion clocks, where k is the 4-bit code. Codes of 8 and above give 1024 clocks. shtLow applies when memSlot is 0..7 and shtHigh when memSlot is 8..15.
- R5: With pulseMode=0 the sample window follows the synchronised request level. Its length matches the request's high time to within one conversion clock.
- R6: trigSel chooses the request: 0 selects swStartBit, and 1, 2, 3 select timerTrig[0], [1], [2]. Activity on an unselected line starts nothing.
- R7: With trigInvert=1 the request is the complement of the selected line. A low-going edge of the line then starts a cycle, and a line held high starts nothing.
- R8: Only a rising edge of the request starts a cycle. Edges that occur while busy is high are ignored.
- R9: busy is high from the opening of the sample window until the result strobe. done is a single-cycle pulse, issued in the cycle busy falls, with result equal to sarCode at the end of conversion.
- R10: A pulse on swStartSet sets swStartBit. The bit clears itself in the cycle done is issued.
- R11: sampleWin and convBusy are never high together, and convBusy implies busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTick | input | 4 | Tick enables of the four candidate clock sources |
| srcSel | input | 2 | Source tick selection |
| clkDiv | input | 3 | Divide factor minus one (0..7 gives /1../8) |
| timerTrig | input | 3 | Timer output request lines |
| trigSel | input | 2 | Request selection (0 = software flag, 1..3 = timer lines) |
| trigInvert | input | 1 | Invert request polarity |
| pulseMode | input | 1 | 1 = timer-defined window, 0 = request-defined window |
| shtLow | input | 4 | Sample-time code for slots 0..7 |
| shtHigh | input | 4 | Sample-time code for slots 8..15 |
| memSlot | input | 4 | Memory slot of the current conversion |
| swStartSet | input | 1 | Sets the software start flag |
| sarCode | input | 12 | Code from the comparator logic |
| swStartBit | output | 1 | Software start flag |
| sampleWin | output | 1 | Sample window |
| convBusy | output | 1 | Conversion window |
| busy | output | 1 | Sampling or converting |
| done | output | 1 | One-cycle result strobe |
| result | output | 12 | Captured conversion code |

## Verification
The checker watches the phase ordering on every cycle. It confirms that sample and conversion windows never overlap, that a closing sample window hands over straight to conversion, that done lasts one cycle and comes only after conversion, and that the software flag drops only together with done. Window lengths can only be measured by the bench's scenarios: sample time per code and slot half, the 13-clock conversion, and the divider and source choices. The same holds for request selection, polarity inversion and the refusal of edges while busy, since each depends on a stimulus history.

// File: rtl/adc_timing_pkg.sv
package adc_timing_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_CONV   = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadResult;
    logic clearStart;
  } ctrlStrobe_t;
endpackage

// File: rtl/adc_timing_dp.sv
module adc_timing_dp
  import adc_timing_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int SRC_N   = 4,
  parameter int TMR_N   = 3,
  parameter int DIV_W   = 3,
  parameter int SHT_W   = 4,
  parameter int SLOT_W  = 4,
  parameter int SAT_EXP = 8,
  parameter int CNT_W   = 11
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [SRC_N-1:0]         srcTick,
  input  logic [$clog2(SRC_N)-1:0] srcSel,
  input  logic [DIV_W-1:0]         clkDiv,
  input  logic [TMR_N-1:0]         timerTrig,
  input  logic [$clog2(TMR_N+1)-1:0] trigSel,
  input  logic                     trigInvert,
  input  logic [SHT_W-1:0]         shtLow,
  input  logic [SHT_W-1:0]         shtHigh,
  input  logic [SLOT_W-1:0]        memSlot,
  input  logic                     swStartSet,
  input  logic [RES_W-1:0]         sarCode,
  input  ctrlStrobe_t              strobe,
  output logic                     convTick,
  output logic                     trigRaw,
  output logic [CNT_W-1:0]         sampleLen,
  output logic                     swStartBit,
  output logic [RES_W-1:0]         result,
  output logic                     done
);
  localparam int HALF_SLOT = 1 << (SLOT_W - 1);
  localparam int REQ_N     = TMR_N + 1;

  // conversion clock enable: divided source ticks
  logic [DIV_W-1:0] divCnt;
  logic             selTick;

  assign selTick  = srcTick[srcSel];
  assign convTick = selTick && (divCnt == clkDiv);

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (selTick) divCnt <= (divCnt == clkDiv) ? '0 : divCnt + 1'b1;
  end

  // request candidates: index 0 is the software flag
  logic [REQ_N-1:0] reqVec;
  assign reqVec[0] = swStartBit;
  for (genvar g = 1; g < REQ_N; g++) begin : gReq
    assign reqVec[g] = timerTrig[g-1];
  end
  assign trigRaw = reqVec[trigSel] ^ trigInvert;

  // sample interval decode with saturation
  logic [SHT_W-1:0] shtCode;
  logic [SHT_W-1:0] shtExp;
  assign shtCode   = (memSlot >= SLOT_W'(HALF_SLOT)) ? shtHigh : shtLow;
  assign shtExp    = (shtCode > SHT_W'(SAT_EXP)) ? SHT_W'(SAT_EXP) : shtCode;
  assign sampleLen = CNT_W'(4) << shtExp;

  // software flag, result capture and strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      swStartBit <= 1'b0;
      result     <= '0;
      done       <= 1'b0;
    end else begin
      done <= strobe.loadResult;
      if (strobe.loadResult) result <= sarCode;
      if (strobe.clearStart) swStartBit <= 1'b0;
      else if (swStartSet)   swStartBit <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_timing_fsm.sv
module adc_timing_fsm
  import adc_timing_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int CONV_CLKS = 13,
  parameter int SYNC_N    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convTick,
  input  logic             trigRaw,
  input  logic             pulseMode,
  input  logic [CNT_W-1:0] sampleLen,
  output ctrlStrobe_t      strobe,
  output logic             sampleWin,
  output logic             convBusy,
  output logic             busy
);
  // synchroniser plus one edge-history stage
  logic [SYNC_N:0] syncQ;
  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else if (convTick) syncQ[0] <= trigRaw;
  end
  for (genvar s = 1; s <= SYNC_N; s++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= 1'b0;
      else if (convTick) syncQ[s] <= syncQ[s-1];
    end
  end

  logic trigLvl, trigRise;
  assign trigLvl  = syncQ[SYNC_N-1];
  assign trigRise = trigLvl && !syncQ[SYNC_N];

  phase_e          phase;
  logic [CNT_W-1:0] cnt;
  logic            sampleEnd, convEnd;

  assign sampleEnd = convTick && (phase == PH_SAMPLE) &&
                     (pulseMode ? (cnt == '0) : !trigLvl);
  assign convEnd   = convTick && (phase == PH_CONV) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (convTick) begin
      unique case (phase)
        PH_IDLE: if (trigRise) begin
          phase <= PH_SAMPLE;
          cnt   <= sampleLen - 1'b1;
        end
        PH_SAMPLE: if (sampleEnd) begin
          phase <= PH_CONV;
          cnt   <= CNT_W'(CONV_CLKS - 1);
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
        PH_CONV: if (convEnd) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign strobe.loadResult = convEnd;
  assign strobe.clearStart = convEnd;
  assign sampleWin = (phase == PH_SAMPLE);
  assign convBusy  = (phase == PH_CONV);
  assign busy      = (phase != PH_IDLE);
endmodule

// File: rtl/adc_timing_ctrl.sv
module adc_timing_ctrl
  import adc_timing_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int DIV_W     = 3,
  parameter int SHT_W     = 4,
  parameter int SLOT_W    = 4,
  parameter int SAT_EXP   = 8,
  parameter int CONV_CLKS = 13,
  parameter int SYNC_N    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       srcTick,
  input  logic [1:0]       srcSel,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [2:0]       timerTrig,
  input  logic [1:0]       trigSel,
  input  logic             trigInvert,
  input  logic             pulseMode,
  input  logic [SHT_W-1:0] shtLow,
  input  logic [SHT_W-1:0] shtHigh,
  input  logic [SLOT_W-1:0] memSlot,
  input  logic             swStartSet,
  input  logic [RES_W-1:0] sarCode,
  output logic             swStartBit,
  output logic             sampleWin,
  output logic             convBusy,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam int MAX_LEN = 4 << SAT_EXP;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  ctrlStrobe_t      strobe;
  logic             convTick, trigRaw;
  logic [CNT_W-1:0] sampleLen;

  adc_timing_dp #(
    .RES_W(RES_W), .SRC_N(4), .TMR_N(3), .DIV_W(DIV_W), .SHT_W(SHT_W),
    .SLOT_W(SLOT_W), .SAT_EXP(SAT_EXP), .CNT_W(CNT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .srcSel(srcSel),
    .clkDiv(clkDiv), .timerTrig(timerTrig), .trigSel(trigSel),
    .trigInvert(trigInvert), .shtLow(shtLow), .shtHigh(shtHigh),
    .memSlot(memSlot), .swStartSet(swStartSet), .sarCode(sarCode),
    .strobe(strobe), .convTick(convTick), .trigRaw(trigRaw),
    .sampleLen(sampleLen), .swStartBit(swStartBit), .result(result),
    .done(done)
  );

  adc_timing_fsm #(
    .CNT_W(CNT_W), .CONV_CLKS(CONV_CLKS), .SYNC_N(SYNC_N)
  ) uFsm (
    .clk(clk), .rstN(rstN), .convTick(convTick), .trigRaw(trigRaw),
    .pulseMode(pulseMode), .sampleLen(sampleLen), .strobe(strobe),
    .sampleWin(sampleWin), .convBusy(convBusy), .busy(busy)
  );
endmodule

// File: rtl/adc_timing_ctrl_sva.sv
module adc_timing_ctrl_sva (
  input logic clk,
  input logic rstN,
  input logic sampleWin,
  input logic convBusy,
  input logic busy,
  input logic done,
  input logic swStartBit
);
  // R11: phases exclusive
  assert_phase_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleWin && convBusy));

  // R11: conversion window implies busy
  assert_conv_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    convBusy |-> busy);

  // R3: closing sample window while busy hands over to conversion
  assert_handover_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sampleWin) && busy) |-> convBusy);

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: done comes right after conversion, with busy low
  assert_done_after_conv_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!busy && $past(convBusy)));

  // R10: software flag clears only together with done
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(swStartBit) |-> done);
endmodule

bind adc_timing_ctrl adc_timing_ctrl_sva uSva (
  .clk(clk), .rstN(rstN), .sampleWin(sampleWin), .convBusy(convBusy),
  .busy(busy), .done(done), .swStartBit(swStartBit)
);

// File: tb/tb_adc_timing_ctrl.sv
`timescale 1ns/1ps
module tb_adc_timing_ctrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  srcTick;
  logic [1:0]  srcSel;
  logic [2:0]  clkDiv;
  logic [2:0]  timerTrig;
  logic [1:0]  trigSel;
  logic        trigInvert, pulseMode, swStartSet;
  logic [3:0]  shtLow, shtHigh, memSlot;
  logic [11:0] sarCode;
  logic        swStartBit, sampleWin, convBusy, busy, done;
  logic [11:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int unsigned cyc = 0;

  always #4 clk = ~clk;

  // source s ticks every s+1 cycles
  always_ff @(posedge clk) cyc <= cyc + 1;
  always_comb begin
    for (int s = 0; s < 4; s++) srcTick[s] = ((cyc % (s + 1)) == 0);
  end

  adc_timing_ctrl dut (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .srcSel(srcSel),
    .clkDiv(clkDiv), .timerTrig(timerTrig), .trigSel(trigSel),
    .trigInvert(trigInvert), .pulseMode(pulseMode), .shtLow(shtLow),
    .shtHigh(shtHigh), .memSlot(memSlot), .swStartSet(swStartSet),
    .sarCode(sarCode), .swStartBit(swStartBit), .sampleWin(sampleWin),
    .convBusy(convBusy), .busy(busy), .done(done), .result(result)
  );

  function automatic int tickPer(input int src, input int div);
    return (src + 1) * (div + 1);
  endfunction

  function automatic int sampleClks(input int code);
    return (code >= 8) ? 1024 : (4 << code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseLine(input int idx, input int len);
    timerTrig[idx] = 1'b1;
    repeat (len) @(negedge clk);
    timerTrig[idx] = 1'b0;
  endtask

  // waits for a window, measures both phases and the strobe
  task automatic measure(output int sw, output int cv, output bit ok,
                         output bit doneAt, output bit busyAt,
                         output bit doneNext, output logic [11:0] res);
    int t = 0;
    ok = 1;
    while (!sampleWin && t < 20000) begin @(negedge clk); t++; end
    if (!sampleWin) ok = 0;
    sw = 0;
    while (sampleWin) begin sw++; @(negedge clk); end
    cv = 0;
    while (convBusy) begin cv++; @(negedge clk); end
    doneAt = done; busyAt = busy; res = result;
    @(negedge clk);
    doneNext = done;
  endtask

  task automatic quietFor(input int n, input string req);
    bit seen = 0;
    repeat (n) begin @(negedge clk); if (busy) seen = 1; end
    check(!seen, req, seen, 0);
  endtask

  task automatic runTimer(input int idx, input int src, input int div,
                          input int code, input string tag);
    int sw, cv, T;
    bit ok, dA, bA, dN;
    logic [11:0] res;
    T = tickPer(src, div);
    sarCode = 12'($urandom);
    fork
      pulseLine(idx, 3 * T);
      measure(sw, cv, ok, dA, bA, dN, res);
    join
    check(ok, {tag, " R6 window opened"}, ok, 1);
    check(sw == sampleClks(code) * T, {tag, " R4 R2 sample length"}, sw, sampleClks(code) * T);
    check(cv == 13 * T, {tag, " R3 R2 conversion length"}, cv, 13 * T);
    check(dA && !bA, {tag, " R9 done with busy low"}, {dA, bA}, 2);
    check(!dN, {tag, " R9 done one cycle"}, dN, 0);
    check(res == sarCode, {tag, " R9 result"}, res, sarCode);
  endtask

  task automatic setCfg(input int src, input int div, input int lo, input int hi,
                        input int slot);
    srcSel = 2'(src); clkDiv = 3'(div);
    shtLow = 4'(lo); shtHigh = 4'(hi); memSlot = 4'(slot);
    repeat (80) @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int sw, cv, T;
    bit ok, dA, bA, dN;
    logic [11:0] res;
    void'($urandom(32'd20240611));
    rstN = 0; srcSel = 0; clkDiv = 0; timerTrig = 0; trigSel = 1;
    trigInvert = 0; pulseMode = 1; swStartSet = 0; shtLow = 0; shtHigh = 0;
    memSlot = 0; sarCode = 0;
    repeat (5) @(negedge clk);
    check(!sampleWin && !convBusy && !busy && !done && !swStartBit && result == 0,
          "R1 reset outputs", {sampleWin, convBusy, busy, done, swStartBit}, 0);
    rstN = 1;
    repeat (10) @(negedge clk);
    check(!busy && !done && result == 0, "R1 idle after reset", busy, 0);

    // directed: pulse mode, low and high slot halves, saturation
    setCfg(0, 0, 2, 9, 3);
    runTimer(0, 0, 0, 2, "lowHalf");
    setCfg(0, 0, 2, 9, 12);
    runTimer(0, 0, 0, 9, "highHalfSat");
    setCfg(0, 0, 7, 0, 7);
    runTimer(0, 0, 0, 7, "code7");
    setCfg(3, 7, 1, 0, 0);
    runTimer(0, 3, 7, 1, "slowClk");

    // R6: unselected line ignored, selected line works
    trigSel = 2;
    setCfg(1, 1, 0, 0, 0);
    pulseLine(2, 12);
    quietFor(60, "R6 unselected line ignored");
    runTimer(1, 1, 1, 0, "sel2");

    // R7: inverted polarity
    trigSel = 3; setCfg(0, 1, 1, 0, 0);
    timerTrig[2] = 1'b1; trigInvert = 1'b1;
    quietFor(60, "R7 held-high inverted line ignored");
    sarCode = 12'h5A3;
    fork
      begin timerTrig[2] = 1'b0; end
      measure(sw, cv, ok, dA, bA, dN, res);
    join
    check(ok && sw == 8 * 2, "R7 falling edge starts window", sw, 16);
    check(res == 12'h5A3, "R7 result", res, 12'h5A3);
    trigInvert = 1'b0;
    quietFor(40, "R7 restore causes no start");

    // R8: edges while busy ignored
    trigSel = 1; setCfg(0, 1, 2, 0, 0);
    T = 2;
    fork
      begin pulseLine(0, 3 * T); repeat (2 * T) @(negedge clk); pulseLine(0, 3 * T); end
      measure(sw, cv, ok, dA, bA, dN, res);
    join
    check(sw == 16 * T, "R8 first request window", sw, 16 * T);
    quietFor(20 * T, "R8 edge during busy ignored");

    // R5: extended mode follows the request level
    pulseMode = 0; setCfg(0, 1, 0, 0, 0);
    T = 2;
    fork
      pulseLine(0, 40);
      measure(sw, cv, ok, dA, bA, dN, res);
    join
    check(ok && sw >= 40 - T && sw <= 40 + T, "R5 extended window length", sw, 40);
    check(cv == 13 * T, "R5 R3 conversion after extended window", cv, 13 * T);
    pulseMode = 1;

    // R10: software start flag
    trigSel = 0; setCfg(2, 0, 1, 0, 0);
    @(negedge clk); swStartSet = 1; @(negedge clk); swStartSet = 0;
    check(swStartBit, "R10 flag set", swStartBit, 1);
    measure(sw, cv, ok, dA, bA, dN, res);
    check(ok && sw == 8 * 3, "R10 R6 software start window", sw, 24);
    check(!swStartBit && dA, "R10 flag self-clears at done", swStartBit, 0);

    // random pulse-mode runs
    for (int i = 0; i < 10; i++) begin
      int src, div, code, slot, idx;
      src = $urandom_range(0, 3); div = $urandom_range(0, 7);
      code = $urandom_range(0, 4); slot = $urandom_range(0, 15);
      idx = $urandom_range(0, 2);
      trigSel = 2'(idx + 1);
      if (slot >= 8) setCfg(src, div, 4 - code, code, slot);
      else setCfg(src, div, code, 4 - code, slot);
      runTimer(idx, src, div, code, "random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule